// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Generator

This block turns a stream of accepted pixel bytes into write cycles for a display memory that holds 4-bit pixels, two per byte. The memory is arranged as 64 byte columns by 80 rows. A column/row cursor selects the byte that receives each incoming data byte, and the byte address is the column plus the row times 64. After each write the cursor moves on inside a rectangular window. A command decoder, which sits outside this block, programs the window.

Two load strobes set the column span and the row span. Each load also puts the cursor on that axis back to the start of the span. A scan-mode input chooses the auto-increment order: row-major, where the column steps first, or column-major, where the row steps first. Every accepted byte also raises a redraw-pending flag. The scan-out logic clears that flag with a single-cycle acknowledge.

Top module: `fbw_cursor_gen`

## Requirements
- R1: After reset, `mem_we` and `redraw_pend` are 0. The window spans columns 0 to 63 and rows 0 to 79, and the cursor is at column 0, row 0, so the first write goes to address 0.
- R2: When a byte is accepted (`wr_valid` high with no load strobe), `mem_we` is high for exactly the next cycle. In that cycle `mem_addr` equals column + row*64 for the cursor as it stood at acceptance, and `mem_wdata` equals the accepted byte.
- R3: With `vert_mode`=0 the column advances by one per write. When the column goes beyond the column end, it returns to the column start and the row advances by one. When the row goes beyond the row end, it returns to the row start.
- R4: With `vert_mode`=1 the row advances by one per write. When the row goes beyond the row end, it returns to the row start and the column advances by one. When the column goes beyond the column end, it returns to the column start.
- R5: A pulse on `col_ld` sets the column start and the column cursor to `col_arg0` mod 64, and sets the column end to `col_arg1` mod 64.
- R6: A pulse on `row_ld` sets the row start and the row cursor to `row_arg0` mod 80, and sets the row end to `row_arg1` mod 80.
- R7: `redraw_pend` becomes 1 in the cycle that `mem_we` is high. A `redraw_ack` pulse with no accepted byte clears it in the next cycle. If a byte is accepted in the same cycle as `redraw_ack`, the flag stays 1.
- R8: If `col_ld` or `row_ld` is high in the same cycle as `wr_valid`, the load takes effect and the byte is dropped. In that case no `mem_we` follows, `redraw_pend` is not set, and the next write goes to the newly loaded start.
- R9: The overrun test is applied on every write, whether or not that axis advanced. If an axis start is beyond its end, each write returns that axis to its start. In row-major mode with a column start of 10 and a column end of 5, for example, successive writes stay at column 10 and step down the rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_ld | input | 1 | Load the column window from the two column arguments |
| col_arg0 | input | 8 | Column start/cursor argument (taken mod 64) |
| col_arg1 | input | 8 | Column end argument (taken mod 64) |
| row_ld | input | 1 | Load the row window from the two row arguments |
| row_arg0 | input | 8 | Row start/cursor argument (taken mod 80) |
| row_arg1 | input | 8 | Row end argument (taken mod 80) |
| vert_mode | input | 1 | 0: column steps first; 1: row steps first |
| wr_valid | input | 1 | Data byte offered this cycle |
| wr_data | input | 8 | Data byte (two 4-bit pixels) |
| redraw_ack | input | 1 | Single-cycle clear of the redraw flag |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 13 | Byte address, column + row*64 |
| mem_wdata | output | 8 | Byte to write |
| redraw_pend | output | 1 | Redraw pending flag |

## Verification
Two pairs of events can land in the same cycle. A window load can arrive with a data byte, and a redraw acknowledge can arrive with a data byte. The bench forces each pair onto one clock edge. In the load case it checks that no write strobe follows, that the redraw flag stays clear, and that the next byte lands at the newly loaded start. In the acknowledge case it checks that the flag still reads 1 in the cycle after the edge.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    typedef enum logic {
        SCAN_ROW_MAJOR = 1'b0,
        SCAN_COL_MAJOR = 1'b1
    } scan_e;

endpackage

// File: rtl/fbw_axis_step.sv
// One cursor axis: optional +1 step followed by the overrun test against the end.
module fbw_axis_step #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] start,
    input  logic [W-1:0] stop,
    input  logic         inc,
    output logic [W-1:0] nxt,
    output logic         over
);
    logic [W:0] bumped;

    always_comb begin
        bumped = {1'b0, cur} + {{W{1'b0}}, inc};
        over   = bumped > {1'b0, stop};
        nxt    = over ? start : bumped[W-1:0];
    end
endmodule

// File: rtl/fbw_addr_calc.sv
// Linear byte address from column and row.
module fbw_addr_calc #(
    parameter int COLS = 64,
    parameter int CW   = 6,
    parameter int RW   = 7,
    parameter int AW   = 13
) (
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    output logic [AW-1:0] addr
);
    always_comb begin
        addr = AW'(col) + AW'(row) * AW'(COLS);
    end
endmodule

// File: rtl/fbw_cursor_gen.sv
module fbw_cursor_gen #(
    parameter int COLS  = 64,
    parameter int ROWS  = 80,
    parameter int ARG_W = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_ld,
    input  logic [ARG_W-1:0] col_arg0,
    input  logic [ARG_W-1:0] col_arg1,
    input  logic             row_ld,
    input  logic [ARG_W-1:0] row_arg0,
    input  logic [ARG_W-1:0] row_arg1,
    input  logic             vert_mode,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             redraw_ack,
    output logic             mem_we,
    output logic [$clog2(COLS*ROWS)-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             redraw_pend
);
    import fbw_pkg::*;

    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);
    localparam int AW = $clog2(COLS*ROWS);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [CW-1:0] col_s;
        logic [CW-1:0] col_e;
        logic [RW-1:0] row;
        logic [RW-1:0] row_s;
        logic [RW-1:0] row_e;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          redraw;
    } state_t;

    state_t st_q, st_d;
    scan_e  scan;

    assign scan = scan_e'(vert_mode);

    // Argument reduction into the legal ranges
    logic [CW-1:0] col_m0, col_m1;
    logic [RW-1:0] row_m0, row_m1;
    always_comb begin
        col_m0 = CW'(col_arg0 % ARG_W'(COLS));
        col_m1 = CW'(col_arg1 % ARG_W'(COLS));
        row_m0 = RW'(row_arg0 % ARG_W'(ROWS));
        row_m1 = RW'(row_arg1 % ARG_W'(ROWS));
    end

    // Row-major pair: column leads, row follows the column overrun
    logic [CW-1:0] h_col;
    logic [RW-1:0] h_row;
    logic          h_col_over, h_row_over;
    // Column-major pair: row leads, column follows the row overrun
    logic [CW-1:0] v_col;
    logic [RW-1:0] v_row;
    logic          v_col_over, v_row_over;

    fbw_axis_step #(.W(CW)) u_h_col (
        .cur(st_q.col), .start(st_q.col_s), .stop(st_q.col_e),
        .inc(1'b1), .nxt(h_col), .over(h_col_over));
    fbw_axis_step #(.W(RW)) u_h_row (
        .cur(st_q.row), .start(st_q.row_s), .stop(st_q.row_e),
        .inc(h_col_over), .nxt(h_row), .over(h_row_over));
    fbw_axis_step #(.W(RW)) u_v_row (
        .cur(st_q.row), .start(st_q.row_s), .stop(st_q.row_e),
        .inc(1'b1), .nxt(v_row), .over(v_row_over));
    fbw_axis_step #(.W(CW)) u_v_col (
        .cur(st_q.col), .start(st_q.col_s), .stop(st_q.col_e),
        .inc(v_row_over), .nxt(v_col), .over(v_col_over));

    logic [AW-1:0] cur_addr;
    fbw_addr_calc #(.COLS(COLS), .CW(CW), .RW(RW), .AW(AW)) u_addr (
        .col(st_q.col), .row(st_q.row), .addr(cur_addr));

    logic any_ld, accept;
    logic unused_over;
    assign any_ld      = col_ld | row_ld;
    assign accept      = wr_valid & ~any_ld;
    assign unused_over = h_row_over ^ v_col_over;

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.addr  = st_q.addr;
        st_d.wdata = st_q.wdata;
        if (redraw_ack) st_d.redraw = 1'b0;
        if (col_ld) begin
            st_d.col   = col_m0;
            st_d.col_s = col_m0;
            st_d.col_e = col_m1;
        end
        if (row_ld) begin
            st_d.row   = row_m0;
            st_d.row_s = row_m0;
            st_d.row_e = row_m1;
        end
        if (accept) begin
            st_d.we     = 1'b1;
            st_d.addr   = cur_addr;
            st_d.wdata  = wr_data;
            st_d.redraw = 1'b1;
            if (scan == SCAN_COL_MAJOR) begin
                st_d.col = v_col;
                st_d.row = v_row;
            end else begin
                st_d.col = h_col;
                st_d.row = h_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.col_e  <= CW'(COLS-1);
            st_q.row_e  <= RW'(ROWS-1);
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we      = st_q.we;
    assign mem_addr    = st_q.addr;
    assign mem_wdata   = st_q.wdata;
    assign redraw_pend = st_q.redraw;

endmodule

// File: rtl/fbw_cursor_chk.sv
module fbw_cursor_chk #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    parameter int DW   = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         col_ld,
    input logic                         row_ld,
    input logic                         wr_valid,
    input logic [DW-1:0]                wr_data,
    input logic                         redraw_ack,
    input logic                         mem_we,
    input logic [$clog2(COLS*ROWS)-1:0] mem_addr,
    input logic [DW-1:0]                mem_wdata,
    input logic                         redraw_pend
);
    localparam int AW = $clog2(COLS*ROWS);

    AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !col_ld && !row_ld) |=> mem_we); // R2
    AST_DATA_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !col_ld && !row_ld) |=> (mem_wdata == $past(wr_data))); // R2
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr < AW'(COLS*ROWS))); // R2
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && !col_ld && !row_ld) |=> !mem_we); // R2
    AST_LOAD_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_ld || row_ld) |=> !mem_we); // R8
    AST_REDRAW_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> redraw_pend); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (redraw_ack && !(wr_valid && !col_ld && !row_ld)) |=> !redraw_pend); // R7
    AST_REDRAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!redraw_ack && redraw_pend) |=> redraw_pend); // R7
endmodule

bind fbw_cursor_gen fbw_cursor_chk #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .col_ld(col_ld), .row_ld(row_ld),
    .wr_valid(wr_valid), .wr_data(wr_data), .redraw_ack(redraw_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redraw_pend(redraw_pend));

// File: tb/tb_fbw_cursor_gen.sv
`timescale 1ns/1ps
module tb_fbw_cursor_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        col_ld = 1'b0, row_ld = 1'b0;
    logic [7:0]  col_arg0 = '0, col_arg1 = '0, row_arg0 = '0, row_arg1 = '0;
    logic        vert_mode = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        redraw_ack = 1'b0;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        redraw_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fbw_cursor_gen dut (
        .clk(clk), .rst_n(rst_n),
        .col_ld(col_ld), .col_arg0(col_arg0), .col_arg1(col_arg1),
        .row_ld(row_ld), .row_arg0(row_arg0), .row_arg1(row_arg1),
        .vert_mode(vert_mode), .wr_valid(wr_valid), .wr_data(wr_data),
        .redraw_ack(redraw_ack), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .redraw_pend(redraw_pend));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cols(input int a0, input int a1);
        @(negedge clk);
        col_ld = 1'b1; col_arg0 = 8'(a0); col_arg1 = 8'(a1);
        @(negedge clk);
        col_ld = 1'b0;
    endtask

    task automatic load_rows(input int a0, input int a1);
        @(negedge clk);
        row_ld = 1'b1; row_arg0 = 8'(a0); row_arg1 = 8'(a1);
        @(negedge clk);
        row_ld = 1'b0;
    endtask

    // Offer one byte, then check the strobe cycle that follows
    task automatic write_chk(input string req, input int data, input int exp_addr);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'(data);
        @(negedge clk);
        wr_valid = 1'b0;
        chk({req, " strobe"}, int'(mem_we), 1);
        chk({req, " addr"}, int'(mem_addr), exp_addr);
        chk({req, " data"}, int'(mem_wdata), data);
    endtask

    task automatic t_reset();
        chk("R1 we after reset", int'(mem_we), 0);
        chk("R1 redraw after reset", int'(redraw_pend), 0);
        write_chk("R1 first write", 8'h5A, 0);
        write_chk("R1 second write", 8'hA5, 1);
        @(negedge clk);
        chk("R2 strobe single cycle", int'(mem_we), 0);
    endtask

    task automatic t_horiz();
        vert_mode = 1'b0;
        load_cols(62, 63);
        load_rows(3, 4);
        write_chk("R3 h0", 8'h11, 62 + 3*64);
        write_chk("R3 h1", 8'h22, 63 + 3*64);
        write_chk("R3 h2 col wrap", 8'h33, 62 + 4*64);
        write_chk("R3 h3", 8'h44, 63 + 4*64);
        write_chk("R3 h4 row wrap", 8'h55, 62 + 3*64);
    endtask

    task automatic t_vert();
        vert_mode = 1'b1;
        load_cols(5, 6);
        load_rows(78, 79);
        write_chk("R4 v0", 8'h01, 5 + 78*64);
        write_chk("R4 v1", 8'h02, 5 + 79*64);
        write_chk("R4 v2 row wrap", 8'h03, 6 + 78*64);
        write_chk("R4 v3", 8'h04, 6 + 79*64);
        write_chk("R4 v4 col wrap", 8'h05, 5 + 78*64);
        vert_mode = 1'b0;
    endtask

    task automatic t_modulo();
        vert_mode = 1'b0;
        load_cols(70, 200);   // start 6, end 8
        load_rows(170, 250);  // start 10, end 10
        write_chk("R5 R6 m0", 8'h10, 6 + 10*64);
        write_chk("R5 m1", 8'h20, 7 + 10*64);
        write_chk("R5 m2", 8'h30, 8 + 10*64);
        write_chk("R6 m3 wrap", 8'h40, 6 + 10*64);
    endtask

    task automatic t_inverted();
        vert_mode = 1'b0;
        load_cols(10, 5);
        load_rows(0, 79);
        write_chk("R9 i0", 8'h77, 10);
        write_chk("R9 i1", 8'h78, 10 + 64);
        write_chk("R9 i2", 8'h79, 10 + 128);
    endtask

    task automatic t_redraw();
        @(negedge clk);
        redraw_ack = 1'b1;
        @(negedge clk);
        redraw_ack = 1'b0;
        chk("R7 ack clears", int'(redraw_pend), 0);
        load_cols(0, 63);
        load_rows(0, 79);
        write_chk("R7 write", 8'h99, 0);
        chk("R7 set on write", int'(redraw_pend), 1);
        @(negedge clk);
        redraw_ack = 1'b1;
        @(negedge clk);
        redraw_ack = 1'b0;
        chk("R7 ack clears again", int'(redraw_pend), 0);
        @(negedge clk);
        redraw_ack = 1'b1; wr_valid = 1'b1; wr_data = 8'hC3;
        @(negedge clk);
        redraw_ack = 1'b0; wr_valid = 1'b0;
        chk("R7 write beats ack", int'(redraw_pend), 1);
        chk("R7 write beats ack strobe", int'(mem_we), 1);
        chk("R7 collide addr", int'(mem_addr), 1);
    endtask

    task automatic t_priority();
        vert_mode = 1'b0;
        load_cols(20, 21);
        load_rows(0, 0);
        @(negedge clk);
        redraw_ack = 1'b1;
        @(negedge clk);
        redraw_ack = 1'b0;
        @(negedge clk);
        col_ld = 1'b1; col_arg0 = 8'd30; col_arg1 = 8'd31;
        wr_valid = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        col_ld = 1'b0; wr_valid = 1'b0;
        chk("R8 no strobe on load", int'(mem_we), 0);
        chk("R8 no redraw on load", int'(redraw_pend), 0);
        write_chk("R8 next at new start", 8'h3C, 30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_horiz();
        t_vert();
        t_modulo();
        t_inverted();
        t_redraw();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule